// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block watches the completed bus cycles of a memory that holds a command channel inside its ordinary read traffic. Software issues a command by reading six addresses in a fixed order. The first five addresses are shared by every command. The sixth address selects one of four operations: store to nonvolatile storage, recall from it, enable automatic store, or disable automatic store. When the block recognises a command, it raises the matching strobe for exactly one clock cycle.

Each input cycle arrives as a one-clock pulse: `rd_done` for a finished read and `wr_done` for a finished write, both sampled together with `addr`. A read counts toward the sequence whether chip enable or output enable qualified it, so output enable does not have to be asserted. Once a command is recognised, `lockout` goes high and blocks array access. It stays high until the controller that carries out the operation pulses `op_done`. All address constants are parameters.

Top module: `cmdseq_detect`

## Requirements
- R1: After a synchronous reset, all four strobes and `lockout` are low, and no sequence progress is held.
- R2: Six consecutive reads at prefix entries 0 through 4, followed by the store address, raise `stb_store` in the cycle after the sixth read is sampled.
- R3: The sixth address selects the strobe. The four strobes correspond, in order, to the store, recall, automatic-store-on and automatic-store-off addresses. A bench packs them as bits 0 to 3 of a nibble {off,on,recall,store}.
- R4: A strobe lasts one cycle, and at most one strobe is high at any time.
- R5: A write cycle that arrives while unlocked, at any point in a sequence, discards all progress.
- R6: A read whose address is not the expected next entry discards progress. If that address equals prefix entry 0, it counts as the first step of a new sequence.
- R7: Cycles with no completed read or write leave progress unchanged, so idle gaps between the six reads are allowed.
- R8: `lockout` rises together with any strobe and stays high until `op_done` is sampled. While it is high, reads and writes are ignored and progress is held at zero.
- R9: An `op_done` pulse while `lockout` is low has no effect on `lockout` or on sequence progress.
- R10: If the sixth read after a valid prefix is not one of the four command addresses, no strobe fires. Matching restarts under the rule in R6.
- R11: When a read and a write complete in the same cycle, the write takes precedence and progress is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_done | input | 1 | One-cycle pulse: a read cycle completed (chip-enable or output-enable qualified) |
| wr_done | input | 1 | One-cycle pulse: a write cycle completed |
| addr | input | ADDR_W | Address of the completed cycle |
| op_done | input | 1 | Controller reports the locked operation finished |
| stb_store | output | 1 | Store command strobe |
| stb_recall | output | 1 | Recall command strobe |
| stb_as_on | output | 1 | Automatic-store enable strobe |
| stb_as_off | output | 1 | Automatic-store disable strobe |
| lockout | output | 1 | Array access blocked until `op_done` |

## Verification
On every cycle, the assertions check that the strobes are one-hot-or-none and one cycle wide, and that `lockout` accompanies each strobe and holds until released. They also check that no strobe can appear while locked, and that progress is zero after a write or during lockout. Only the bench scenarios can show which address orders fire which command. These scenarios cover writes and stray addresses injected at each of the six positions, restart on prefix entry 0, idle gaps, a simultaneous read and write, and a full sequence sent while locked having no effect.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_STORE  = 3'd1,
    CMD_RECALL = 3'd2,
    CMD_AS_ON  = 3'd3,
    CMD_AS_OFF = 3'd4
  } cmd_e;

  localparam int unsigned NUM_CMDS = 4;
  localparam int unsigned SEQ_LEN  = 6;
  localparam int unsigned PRE_LEN  = SEQ_LEN - 1;
  localparam int unsigned IDX_W    = $clog2(SEQ_LEN);
endpackage

// File: rtl/cmdseq_final_decode.sv
module cmdseq_final_decode
  import cmdseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] A_STORE  = 16'h35E9,
  parameter logic [ADDR_W-1:0] A_RECALL = 16'h5C17,
  parameter logic [ADDR_W-1:0] A_AS_ON  = 16'h2A74,
  parameter logic [ADDR_W-1:0] A_AS_OFF = 16'h18C2
) (
  input  logic [ADDR_W-1:0] addr,
  output cmd_e              cmd
);
  always_comb begin
    cmd = CMD_NONE;
    if      (addr == A_STORE)  cmd = CMD_STORE;
    else if (addr == A_RECALL) cmd = CMD_RECALL;
    else if (addr == A_AS_ON)  cmd = CMD_AS_ON;
    else if (addr == A_AS_OFF) cmd = CMD_AS_OFF;
  end
endmodule

// File: rtl/cmdseq_matcher.sv
module cmdseq_matcher
  import cmdseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [PRE_LEN*ADDR_W-1:0] PREFIX = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_done,
  input  logic              wr_done,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lockout,
  input  cmd_e              final_cmd,
  output logic              hit
);
  logic [IDX_W-1:0]   idx;
  logic [PRE_LEN-1:0] eq;

  for (genvar i = 0; i < PRE_LEN; i++) begin : g_cmp
    assign eq[i] = (addr == PREFIX[i*ADDR_W +: ADDR_W]);
  end

  logic at_final, rd_live, step_ok;
  assign at_final = (idx == IDX_W'(PRE_LEN));
  assign rd_live  = rd_done && !wr_done && !lockout;
  assign step_ok  = !at_final && eq[idx];
  assign hit      = rd_live && at_final && (final_cmd != CMD_NONE);

  always_ff @(posedge clk) begin
    if (rst || lockout || wr_done) begin
      idx <= '0;
    end else if (rd_done) begin
      if (step_ok)      idx <= idx + 1'b1;
      else if (hit)     idx <= '0;
      else if (eq[0])   idx <= IDX_W'(1);
      else              idx <= '0;
    end
  end

  a_r6_idx_range: assert property (@(posedge clk) disable iff (rst)
    idx <= IDX_W'(PRE_LEN));
  a_r5_write_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_done && !lockout) |=> (idx == '0));
  a_r8_locked_idle: assert property (@(posedge clk) disable iff (rst)
    lockout |=> (idx == '0));
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!rd_done && !wr_done && !lockout) |=> $stable(idx));
endmodule

// File: rtl/cmdseq_lock.sv
module cmdseq_lock
  import cmdseq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                hit,
  input  cmd_e                cmd,
  input  logic                op_done,
  output logic [NUM_CMDS-1:0] stb,
  output logic                lockout
);
  logic [NUM_CMDS-1:0] stb_next;

  for (genvar c = 0; c < NUM_CMDS; c++) begin : g_stb
    assign stb_next[c] = hit && (cmd == cmd_e'(c + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb     <= '0;
      lockout <= 1'b0;
    end else begin
      stb <= lockout ? '0 : stb_next;
      if (lockout) lockout <= !op_done;
      else         lockout <= hit;
    end
  end

  a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (stb != '0) |=> (stb == '0));
  a_r8_lock_with_stb: assert property (@(posedge clk) disable iff (rst)
    (stb != '0) |-> lockout);
  a_r8_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (lockout && !op_done) |=> lockout);
  a_r8_no_stb_locked: assert property (@(posedge clk) disable iff (rst)
    lockout |=> (stb == '0));
  a_r9_done_unlocked: assert property (@(posedge clk) disable iff (rst)
    (!lockout && !hit) |=> !lockout);
endmodule

// File: rtl/cmdseq_detect.sv
module cmdseq_detect
  import cmdseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] A_P0 = 16'h4E21,
  parameter logic [ADDR_W-1:0] A_P1 = 16'h1BD3,
  parameter logic [ADDR_W-1:0] A_P2 = 16'h7A06,
  parameter logic [ADDR_W-1:0] A_P3 = 16'h0C5F,
  parameter logic [ADDR_W-1:0] A_P4 = 16'h62B8,
  parameter logic [ADDR_W-1:0] A_STORE  = 16'h35E9,
  parameter logic [ADDR_W-1:0] A_RECALL = 16'h5C17,
  parameter logic [ADDR_W-1:0] A_AS_ON  = 16'h2A74,
  parameter logic [ADDR_W-1:0] A_AS_OFF = 16'h18C2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_done,
  input  logic              wr_done,
  input  logic [ADDR_W-1:0] addr,
  input  logic              op_done,
  output logic              stb_store,
  output logic              stb_recall,
  output logic              stb_as_on,
  output logic              stb_as_off,
  output logic              lockout
);
  localparam logic [PRE_LEN*ADDR_W-1:0] PREFIX = {A_P4, A_P3, A_P2, A_P1, A_P0};

  cmd_e                final_cmd;
  logic                hit;
  logic [NUM_CMDS-1:0] stb;

  cmdseq_final_decode #(
    .ADDR_W(ADDR_W), .A_STORE(A_STORE), .A_RECALL(A_RECALL),
    .A_AS_ON(A_AS_ON), .A_AS_OFF(A_AS_OFF)
  ) u_dec (
    .addr(addr), .cmd(final_cmd)
  );

  cmdseq_matcher #(.ADDR_W(ADDR_W), .PREFIX(PREFIX)) u_match (
    .clk(clk), .rst(rst), .rd_done(rd_done), .wr_done(wr_done),
    .addr(addr), .lockout(lockout), .final_cmd(final_cmd), .hit(hit)
  );

  cmdseq_lock u_lock (
    .clk(clk), .rst(rst), .hit(hit), .cmd(final_cmd),
    .op_done(op_done), .stb(stb), .lockout(lockout)
  );

  assign stb_store  = stb[0];
  assign stb_recall = stb[1];
  assign stb_as_on  = stb[2];
  assign stb_as_off = stb[3];
endmodule

// File: tb/cmdseq_detect_tb.sv
module cmdseq_detect_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_done = 1'b0, wr_done = 1'b0, op_done = 1'b0;
  logic [15:0] addr = '0;
  logic stb_store, stb_recall, stb_as_on, stb_as_off, lockout;
  int checks = 0, fails = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  cmdseq_detect u_dut (
    .clk(clk), .rst(rst), .rd_done(rd_done), .wr_done(wr_done), .addr(addr),
    .op_done(op_done), .stb_store(stb_store), .stb_recall(stb_recall),
    .stb_as_on(stb_as_on), .stb_as_off(stb_as_off), .lockout(lockout)
  );

  function automatic logic [15:0] seq(int i, int c);
    case (i)
      0: return 16'h4E21;
      1: return 16'h1BD3;
      2: return 16'h7A06;
      3: return 16'h0C5F;
      4: return 16'h62B8;
      default: case (c)
        0: return 16'h35E9;
        1: return 16'h5C17;
        2: return 16'h2A74;
        default: return 16'h18C2;
      endcase
    endcase
  endfunction

  localparam logic [15:0] BAD = 16'h7FFF;

  function automatic logic [3:0] obs();
    return {stb_as_off, stb_as_on, stb_recall, stb_store};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit r, bit w, logic [15:0] a);
    @(negedge clk);
    rd_done = r; wr_done = w; addr = a;
    @(posedge clk); #1;
    rd_done = 0; wr_done = 0;
  endtask

  task automatic rd(logic [15:0] a); cyc(1, 0, a); endtask
  task automatic wr(logic [15:0] a); cyc(0, 1, a); endtask
  task automatic idle(); cyc(0, 0, 16'h0); endtask

  task automatic release_lock();
    @(negedge clk); op_done = 1;
    @(posedge clk); #1; op_done = 0;
  endtask

  task automatic expect_end(int cmd, string req);
    logic [3:0] e;
    e = (cmd < 0) ? 4'h0 : 4'(1 << cmd);
    chk(obs() == e, req, obs(), e);
    chk(lockout == (cmd >= 0), req, lockout, cmd >= 0);
    if (cmd >= 0) release_lock();
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(obs() == 0 && lockout == 0, "R1 reset", {lockout, obs()}, 0);
    @(negedge clk); rst = 0;

    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 6; i++) rd(seq(i, c));
      chk(obs() == 4'(1 << c), "R2 R3 strobe", obs(), 1 << c);
      chk(lockout == 1, "R8 lock rises", lockout, 1);
      idle();
      chk(obs() == 0, "R4 one cycle", obs(), 0);
      chk(lockout == 1, "R8 lock holds", lockout, 1);
      release_lock();
      chk(lockout == 0, "R8 release", lockout, 0);
    end

    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 6; p++) begin
        for (int i = 0; i < p; i++) rd(seq(i, c));
        wr(seq(p, c));
        for (int i = p; i < 6; i++) rd(seq(i, c));
        expect_end(p == 0 ? c : -1, "R5 write abort");
        wr(BAD);
      end

    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 6; p++) begin
        for (int i = 0; i < p; i++) rd(seq(i, c));
        rd(BAD);
        for (int i = p; i < 6; i++) rd(seq(i, c));
        expect_end(p == 0 ? c : -1, "R6 mismatch");
        wr(BAD);
      end

    for (int p = 1; p < 6; p++) begin
      for (int i = 0; i < p; i++) rd(seq(i, 1));
      rd(seq(0, 1));
      for (int i = 1; i < 6; i++) rd(seq(i, 1));
      expect_end(1, "R6 restart on first");
    end

    for (int g = 0; g < 4; g++) begin
      for (int i = 0; i < 6; i++) begin
        rd(seq(i, 2));
        if (i < 5) for (int k = 0; k < g; k++) idle();
      end
      expect_end(2, "R7 gaps");
    end

    for (int i = 0; i < 5; i++) rd(seq(i, 0));
    rd(BAD);
    expect_end(-1, "R10 unknown final");
    for (int i = 0; i < 5; i++) rd(seq(i, 0));
    rd(seq(0, 0));
    for (int i = 1; i < 6; i++) rd(seq(i, 3));
    expect_end(3, "R10 final as first");

    for (int i = 0; i < 3; i++) rd(seq(i, 0));
    cyc(1, 1, seq(3, 0));
    for (int i = 4; i < 6; i++) rd(seq(i, 0));
    expect_end(-1, "R11 write wins");

    for (int i = 0; i < 6; i++) rd(seq(i, 0));
    chk(lockout == 1, "R8 locked", lockout, 1);
    for (int i = 0; i < 6; i++) begin
      rd(seq(i, 1));
      chk(obs() == 0 && lockout == 1, "R8 ignored while locked", {lockout, obs()}, 5'h10);
    end
    wr(BAD);
    chk(lockout == 1, "R8 write ignored", lockout, 1);
    for (int i = 0; i < 3; i++) rd(seq(i, 1));
    release_lock();
    for (int i = 3; i < 6; i++) rd(seq(i, 1));
    expect_end(-1, "R8 progress cleared");

    for (int i = 0; i < 3; i++) rd(seq(i, 3));
    release_lock();
    chk(lockout == 0, "R9 done unlocked", lockout, 0);
    for (int i = 3; i < 6; i++) rd(seq(i, 3));
    expect_end(3, "R9 progress kept");

    report();
  end
endmodule